// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller that sits in front of a successive-approximation converter. It runs from the system clock and makes a conversion tick, a single-cycle enable strobe, by dividing that clock by a programmable amount. A one-cycle request starts a conversion. The settings presented on that cycle are captured: resolution, calibration on or off, power-down on or off, divider select and sample length. The block then leaves the converter powered on and runs a sample window of programmable length. After that it resolves the result one bit per tick, from the most significant bit down, against an external comparator. It may add two calibration ticks. It then hands over a left-justified 12-bit code with a one-cycle valid strobe.

The result is built in a trial register. For each bit, the block drives a trial code to the external DAC. It keeps that bit when the comparator reports that the held input is at least the trial code. If the previous conversion asked for power-down, the converter stays powered down until the next accepted request, and that request then spends one extra tick waking up before sampling starts.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset the outputs are as follows: `conv_busy`, `samp_active`, `cal_active` and `res_valid` are 0; `res_data` and `dac_trial` are 0; `pwr_off` is 1.
- R2: The resolution is set by `cfg_mode[1:0]`. Code 01 gives 12 bits, 00 gives 10 bits and 10 gives 8 bits. The result in `res_data` is left-justified: bit 11 is the MSB and the unused low bits are 0. The result equals the largest such code not exceeding the input that the comparator judges. Each trial code on `dac_trial` is the bits kept so far plus the bit under test, in the same left-justified layout, and `dac_trial` is 0 outside the approximation phase.
- R3: One conversion tick lasts 4 × (`div_sel` + 1) clock cycles, counted from the edge that accepts the request. The request-to-valid latency is that tick length times the number of ticks. The tick count is (1 if waking) + (`samp_len` + 2) + bits + (2 if calibrating).
- R4: The sample window lasts (`samp_len` + 2) ticks. `samp_active` is high only while `conv_busy` is high, and `conv_busy` is already high when `samp_active` rises.
- R5: With `cfg_mode[3]` = 0, two calibration ticks follow the last bit, with `cal_active` high during them. With `cfg_mode[3]` = 1, there are none.
- R6: With `cfg_mode[2]` = 0, `pwr_off` rises when the result is delivered and stays high until the next accepted request. With `cfg_mode[2]` = 1, it stays low. `pwr_off` falls on the accepting edge. A request accepted while `pwr_off` is high adds one wake-up tick before sampling.
- R7: A request with `cfg_mode[1:0]` = 11 is not accepted: `conv_busy` stays low and `pwr_off` is unchanged.
- R8: A request while `conv_busy` is high is ignored. Mode, divider select and sample length are used as captured on the accepting edge, so later changes to those inputs have no effect on the running conversion.
- R9: `res_data` changes only on the edge that also drops `conv_busy` and raises `res_valid`. `res_valid` is high for exactly one cycle, and `res_data` holds until the next delivery.
- R10: A request made in the cycle in which `res_valid` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_req | input | 1 | Conversion request, sampled on the rising edge |
| cfg_mode | input | 4 | [3] calibration skip, [2] stay powered, [1:0] resolution |
| div_sel | input | 8 | Conversion tick divider select |
| samp_len | input | 8 | Sample window length select |
| cmp_ge | input | 1 | Comparator: held input is at least `dac_trial` |
| dac_trial | output | 12 | Trial code for the external DAC, left-justified |
| conv_busy | output | 1 | Conversion in progress |
| samp_active | output | 1 | Sample window active |
| cal_active | output | 1 | Calibration ticks active |
| res_valid | output | 1 | One-cycle result strobe |
| pwr_off | output | 1 | Converter powered down |
| res_data | output | 12 | Left-justified result |

## Verification
Delivery of a result and acceptance of the next request can fall in the same cycle. `res_valid` is high while `conv_busy` has just dropped. The bench provokes this by raising `conv_req` at the very clock phase in which it sees `res_valid`. The scoreboard then checks two things: the first result is intact, and the second conversion's latency, including a wake-up tick only when the first asked for power-down, matches the tick formula counted from that edge. A request raised during a running conversion is also judged through the scoreboard. It must leave both the busy flag and the running conversion's result and timing untouched.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_WAKE   = 3'd1,
      PH_SAMP   = 3'd2,
      PH_APPROX = 3'd3,
      PH_CAL    = 3'd4
   } phase_e;

   // resolution codes on the mode field [1:0]
   localparam logic [1:0] RES_MID  = 2'b00;
   localparam logic [1:0] RES_FULL = 2'b01;
   localparam logic [1:0] RES_LOW  = 2'b10;
   localparam logic [1:0] RES_BAD  = 2'b11;

   // number of forced-zero low bits for a resolution code
   function automatic int unsigned drop_bits(input logic [1:0] rc);
      case (rc)
         RES_MID: return 2;
         RES_LOW: return 4;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
   parameter int DIV_W = 8,
   parameter int MULT  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             run,
   input  logic [DIV_W-1:0] div_in,
   output logic             tick
);
   localparam int MUL_SH = (MULT > 1) ? $clog2(MULT) : 0;
   localparam int CNT_W  = DIV_W + MUL_SH + 1;

   generate
      if (MULT < 1) begin : g_bad_mult
         $error("sar_tick_gen: MULT must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] period_calc;
   logic [CNT_W-1:0] span_q;
   logic [CNT_W-1:0] cnt_q;

   generate
      if ((1 << MUL_SH) == MULT) begin : g_pow2
         assign period_calc = CNT_W'((CNT_W'(div_in) + CNT_W'(1)) << MUL_SH);
      end else begin : g_mult
         assign period_calc = CNT_W'((CNT_W'(div_in) + CNT_W'(1)) * CNT_W'(MULT));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         span_q <= '0;
         cnt_q  <= '0;
      end else if (load) begin
         span_q <= period_calc - CNT_W'(1);
         cnt_q  <= period_calc - CNT_W'(1);
      end else if (run) begin
         cnt_q <= (cnt_q == '0) ? span_q : cnt_q - CNT_W'(1);
      end
   end

   assign tick = run && (cnt_q == '0);

endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg
   import sar_conv_pkg::*;
#(
   parameter int RES_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic             cmp_ge,
   input  logic [1:0]       res_code,
   output logic [RES_W-1:0] trial,
   output logic [RES_W-1:0] code_now,
   output logic [RES_W-1:0] code_next,
   output logic             last_bit
);
   logic [RES_W-1:0] sar_q;
   logic [RES_W-1:0] ptr_q;
   logic [RES_W-1:0] lsb_sel;

   always_comb begin
      lsb_sel = RES_W'(1) << drop_bits(res_code);
   end

   // one decision flop per result bit
   generate
      for (genvar i = 0; i < RES_W; i++) begin : g_bit
         always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
               sar_q[i] <= 1'b0;
            end else if (step && ptr_q[i] && cmp_ge) begin
               sar_q[i] <= 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (clr) begin
         ptr_q <= RES_W'(1) << (RES_W - 1);
      end else if (step) begin
         ptr_q <= ptr_q >> 1;
      end
   end

   assign trial     = sar_q | ptr_q;
   assign code_now  = sar_q;
   assign code_next = cmp_ge ? (sar_q | ptr_q) : sar_q;
   assign last_bit  = |(ptr_q & lsb_sel);

endmodule

// File: rtl/sar_phase_ctl.sv
module sar_phase_ctl
   import sar_conv_pkg::*;
#(
   parameter int SLEN_W  = 8,
   parameter int CAL_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              wake_req,
   input  logic              tick,
   input  logic [SLEN_W-1:0] slen,
   input  logic              cal_en,
   input  logic              last_bit,
   output phase_e            phase,
   output logic              approx_clr,
   output logic              approx_step,
   output logic              finish
);
   localparam int  CCNT_W  = (CAL_CYC > 1) ? $clog2(CAL_CYC) : 1;
   localparam bit  HAS_CAL = (CAL_CYC > 0);

   phase_e              phase_q;
   logic [SLEN_W:0]     scnt_q;
   logic [CCNT_W-1:0]   ccnt_q;
   logic [SLEN_W:0]     samp_end;
   logic                last_step;
   logic                to_cal;
   logic                cal_done;

   assign samp_end    = (SLEN_W+1)'(slen) + (SLEN_W+1)'(1);
   assign approx_clr  = tick && (phase_q == PH_SAMP) && (scnt_q == samp_end);
   assign approx_step = tick && (phase_q == PH_APPROX);
   assign last_step   = approx_step && last_bit;
   assign to_cal      = last_step && cal_en && HAS_CAL;
   assign cal_done    = tick && (phase_q == PH_CAL) && (ccnt_q == CCNT_W'(CAL_CYC - 1));
   assign finish      = (last_step && !to_cal) || cal_done;
   assign phase       = phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         scnt_q  <= '0;
         ccnt_q  <= '0;
      end else begin
         case (phase_q)
            PH_IDLE: if (accept) begin
               phase_q <= wake_req ? PH_WAKE : PH_SAMP;
               scnt_q  <= '0;
            end
            PH_WAKE: if (tick) begin
               phase_q <= PH_SAMP;
               scnt_q  <= '0;
            end
            PH_SAMP: if (tick) begin
               if (scnt_q == samp_end) phase_q <= PH_APPROX;
               else                    scnt_q  <= scnt_q + 1'b1;
            end
            PH_APPROX: if (last_step) begin
               phase_q <= to_cal ? PH_CAL : PH_IDLE;
               ccnt_q  <= '0;
            end
            PH_CAL: if (tick) begin
               if (cal_done) phase_q <= PH_IDLE;
               else          ccnt_q  <= ccnt_q + 1'b1;
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
   import sar_conv_pkg::*;
#(
   parameter int RES_W    = 12,
   parameter int DIV_W    = 8,
   parameter int SLEN_W   = 8,
   parameter int CLK_MULT = 4,
   parameter int CAL_CYC  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_req,
   input  logic [3:0]        cfg_mode,
   input  logic [DIV_W-1:0]  div_sel,
   input  logic [SLEN_W-1:0] samp_len,
   input  logic              cmp_ge,
   output logic [RES_W-1:0]  dac_trial,
   output logic              conv_busy,
   output logic              samp_active,
   output logic              cal_active,
   output logic              res_valid,
   output logic              pwr_off,
   output logic [RES_W-1:0]  res_data
);
   generate
      if (RES_W < 5) begin : g_bad_res
         $error("sar_conv_seq: RES_W must exceed the 4 dropped bits of the low mode");
      end
      if (DIV_W < 1 || SLEN_W < 1) begin : g_bad_w
         $error("sar_conv_seq: divider and sample widths must be positive");
      end
   endgenerate

   phase_e            phase;
   logic [3:0]        mode_q;
   logic [SLEN_W-1:0] slen_q;
   logic              pd_q;
   logic              dv_q;
   logic [RES_W-1:0]  res_q;

   logic              accept;
   logic              tick;
   logic              approx_clr;
   logic              approx_step;
   logic              finish;
   logic              last_bit;
   logic [RES_W-1:0]  trial;
   logic [RES_W-1:0]  code_now;
   logic [RES_W-1:0]  code_next;

   assign accept = conv_req && (phase == PH_IDLE) && (cfg_mode[1:0] != RES_BAD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
         slen_q <= '0;
         pd_q   <= 1'b1;
         dv_q   <= 1'b0;
         res_q  <= '0;
      end else begin
         dv_q <= finish;
         if (accept) begin
            mode_q <= cfg_mode;
            slen_q <= samp_len;
            pd_q   <= 1'b0;
         end else if (finish) begin
            pd_q   <= ~mode_q[2];
         end
         if (finish) begin
            res_q <= (phase == PH_APPROX) ? code_next : code_now;
         end
      end
   end

   sar_tick_gen #(
      .DIV_W (DIV_W),
      .MULT  (CLK_MULT)
   ) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (accept),
      .run    (phase != PH_IDLE),
      .div_in (div_sel),
      .tick   (tick)
   );

   sar_phase_ctl #(
      .SLEN_W  (SLEN_W),
      .CAL_CYC (CAL_CYC)
   ) u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept      (accept),
      .wake_req    (pd_q),
      .tick        (tick),
      .slen        (slen_q),
      .cal_en      (~mode_q[3]),
      .last_bit    (last_bit),
      .phase       (phase),
      .approx_clr  (approx_clr),
      .approx_step (approx_step),
      .finish      (finish)
   );

   sar_approx_reg #(
      .RES_W (RES_W)
   ) u_sar (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (approx_clr),
      .step      (approx_step),
      .cmp_ge    (cmp_ge),
      .res_code  (mode_q[1:0]),
      .trial     (trial),
      .code_now  (code_now),
      .code_next (code_next),
      .last_bit  (last_bit)
   );

   assign dac_trial   = (phase == PH_APPROX) ? trial : '0;
   assign conv_busy   = (phase != PH_IDLE);
   assign samp_active = (phase == PH_SAMP);
   assign cal_active  = (phase == PH_CAL);
   assign res_valid   = dv_q;
   assign pwr_off     = pd_q;
   assign res_data    = res_q;

endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
   parameter int RES_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             conv_req,
   input logic [3:0]       cfg_mode,
   input logic [RES_W-1:0] dac_trial,
   input logic             conv_busy,
   input logic             samp_active,
   input logic             cal_active,
   input logic             res_valid,
   input logic             pwr_off,
   input logic [RES_W-1:0] res_data,
   input logic [1:0]       res_code
);
   p_dac_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_busy |-> (dac_trial == '0));

   p_low_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_code == 2'b10) |-> (res_data[3:0] == 4'h0));

   p_mid_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_code == 2'b00) |-> (res_data[1:0] == 2'b00));

   p_samp_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      samp_active |-> conv_busy);

   p_cal_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cal_active |-> (conv_busy && !samp_active));

   p_pd_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_off |-> !conv_busy);

   p_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_req && !conv_busy && cfg_mode[1:0] == 2'b11) |=> !conv_busy);

   p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_busy && conv_req) |=> (conv_busy || res_valid));

   p_dv_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   p_dv_busy_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $fell(conv_busy));

   p_res_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> $stable(res_data));

endmodule

bind sar_conv_seq sar_conv_seq_chk #(.RES_W(RES_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .conv_req    (conv_req),
   .cfg_mode    (cfg_mode),
   .dac_trial   (dac_trial),
   .conv_busy   (conv_busy),
   .samp_active (samp_active),
   .cal_active  (cal_active),
   .res_valid   (res_valid),
   .pwr_off     (pwr_off),
   .res_data    (res_data),
   .res_code    (mode_q[1:0])
);

// File: tb/sar_conv_seq_tb.sv
`timescale 1ns/1ps
module sar_conv_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        conv_req = 1'b0;
   logic [3:0]  cfg_mode = 4'h0;
   logic [7:0]  div_sel = 8'h0;
   logic [7:0]  samp_len = 8'h0;
   logic        cmp_ge;
   logic [11:0] dac_trial;
   logic        conv_busy, samp_active, cal_active, res_valid, pwr_off;
   logic [11:0] res_data;
   logic [11:0] vin = 12'h0;

   always #2 clk = ~clk;

   // behavioural comparator and DAC
   assign cmp_ge = (vin >= dac_trial);

   sar_conv_seq u_dut (
      .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .cfg_mode(cfg_mode),
      .div_sel(div_sel), .samp_len(samp_len), .cmp_ge(cmp_ge),
      .dac_trial(dac_trial), .conv_busy(conv_busy), .samp_active(samp_active),
      .cal_active(cal_active), .res_valid(res_valid), .pwr_off(pwr_off),
      .res_data(res_data)
   );

   typedef struct {
      logic [11:0] res;
      int          lat;
      int          smp;
      int          cal;
      logic        pd;
      int          t0;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0;
   int   fails  = 0;
   int   cyc    = 0;
   logic model_pd = 1'b1;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string tag, input int act, input int expv);
      checks++;
      if (act != expv) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
      end
   endtask

   // driver: called at a negedge, request lands on the next rising edge
   task automatic issue(input logic [3:0] m, input logic [7:0] d,
                        input logic [7:0] s, input logic [11:0] v);
      exp_t e;
      int   nb;
      int   per;
      int   k;
      nb  = (m[1:0] == 2'b01) ? 12 : (m[1:0] == 2'b00) ? 10 : 8;
      per = 4 * (int'(d) + 1);
      k   = (model_pd ? 1 : 0) + int'(s) + 2 + nb + (m[3] ? 0 : 2);
      e.res = v & (12'hFFF << (12 - nb));
      e.lat = per * k;
      e.smp = (int'(s) + 2) * per;
      e.cal = m[3] ? 0 : 2 * per;
      e.pd  = ~m[2];
      e.t0  = cyc + 1;
      exp_q.push_back(e);
      model_pd = ~m[2];
      vin      = v;
      cfg_mode = m;
      div_sel  = d;
      samp_len = s;
      conv_req = 1'b1;
      @(negedge clk);
      conv_req = 1'b0;
      // scramble settings: captured copies must be used (R8)
      cfg_mode = ~m;
      div_sel  = d ^ 8'h5A;
      samp_len = s ^ 8'hC3;
      chk("R6 pwr_off cleared on accept", int'(pwr_off), 0);
      chk("R4 busy after accept", int'(conv_busy), 1);
   endtask

   task automatic wait_dv();
      do @(negedge clk); while (!res_valid);
   endtask

   // monitor / scoreboard
   int   smp_cnt = 0;
   int   cal_cnt = 0;
   logic prev_samp = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (samp_active) smp_cnt++;
         if (cal_active)  cal_cnt++;
         if (samp_active && !prev_samp)
            chk("R4 busy high when sampling starts", int'(conv_busy), 1);
         if (res_valid) begin
            if (exp_q.size() == 0) begin
               checks++; fails++;
               $display("FAIL R9 unexpected result: actual 0x%0h expected none", res_data);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk("R2 result", int'(res_data), int'(e.res));
               chk("R3 latency", cyc - e.t0, e.lat);
               chk("R4 sample length", smp_cnt, e.smp);
               chk("R5 calibration length", cal_cnt, e.cal);
               chk("R6 pwr_off after result", int'(pwr_off), int'(e.pd));
               chk("R9 busy low with valid", int'(conv_busy), 0);
            end
            smp_cnt = 0;
            cal_cnt = 0;
         end
         prev_samp = samp_active;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      // R1 reset state
      chk("R1 busy", int'(conv_busy), 0);
      chk("R1 sample", int'(samp_active), 0);
      chk("R1 cal", int'(cal_active), 0);
      chk("R1 valid", int'(res_valid), 0);
      chk("R1 result", int'(res_data), 0);
      chk("R1 dac", int'(dac_trial), 0);
      chk("R1 pwr_off", int'(pwr_off), 1);
      rst_n = 1'b1;
      @(negedge clk);

      // 12-bit, calibrate, stay powered (wake from reset)
      issue(4'b0101, 8'd0, 8'd0, 12'hA5C); wait_dv(); @(negedge clk);
      // 10-bit, no calibration, power down
      issue(4'b1000, 8'd1, 8'd3, 12'h3FF); wait_dv(); @(negedge clk);
      // 8-bit, calibrate, power down (wake tick)
      issue(4'b0010, 8'd2, 8'd5, 12'hFFF); wait_dv(); @(negedge clk);
      // 12-bit zero input, longest sample window
      issue(4'b1101, 8'd0, 8'd255, 12'h000); wait_dv(); @(negedge clk);

      // R7: reserved resolution code is not accepted
      cfg_mode = 4'b0111; conv_req = 1'b1;
      @(negedge clk);
      conv_req = 1'b0;
      repeat (3) @(negedge clk);
      chk("R7 rejected busy", int'(conv_busy), 0);
      chk("R7 pwr_off unchanged", int'(pwr_off), int'(model_pd));

      // R8: request during a running conversion is ignored
      issue(4'b0101, 8'd1, 8'd2, 12'h801);
      repeat (20) @(negedge clk);
      cfg_mode = 4'b0110; div_sel = 8'd0; samp_len = 8'd0; conv_req = 1'b1;
      @(negedge clk);
      conv_req = 1'b0;
      chk("R8 still busy", int'(conv_busy), 1);
      wait_dv();

      // R10: request in the valid cycle is accepted
      chk("R10 valid cycle idle", int'(conv_busy), 0);
      issue(4'b1100, 8'd0, 8'd1, 12'h155);
      wait_dv();
      issue(4'b1010, 8'd0, 8'd0, 12'h7F3);
      wait_dv(); @(negedge clk);

      // long conversion tick
      issue(4'b1010, 8'd255, 8'd0, 12'h7F3); wait_dv(); @(negedge clk);

      // sweep of patterns
      for (int i = 0; i < 6; i++) begin
         logic [3:0] m;
         m = {i[0], i[1], (i % 3 == 0) ? 2'b01 : (i % 3 == 1) ? 2'b00 : 2'b10};
         issue(m, 8'(i % 3), 8'(i), 12'(i * 12'h2F1 + 12'h013));
         wait_dv(); @(negedge clk);
      end

      repeat (4) @(negedge clk);
      chk("R9 no outstanding results", exp_q.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule